// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block is an 8-bit event counter paired with a watchdog counter. Both draw on one programmable prescaler, and a control word decides which of them owns it. The timer can count instruction cycles, which are the cycles of `clk`. It can also count edges of an external pin or edges of a comparator output. The two asynchronous inputs each pass through a two-stage synchronizer before their edges are detected.

The watchdog counts pulses from a separate slow oscillator. That oscillator is presented to the block as a one-cycle pulse on `wdt_tick`. When the watchdog counter wraps, the block raises a one-cycle time-out pulse. A clear instruction restarts the watchdog.

The core can write the timer at any time. After each write, the timer skips two instruction cycles. While the external pin is the timer's clock source, the block forces that pin's direction to input.

Top module: `tmr_wdt_prescale`

## Requirements
- R1: After reset, `tmr_q` is 0 and `wdt_to` is 0. The control word resets to all ones: external pin source, falling edge, prescaler owned by the watchdog, ratio 7.
- R2: The control word (`ctl_wdata`, loaded when `ctl_wr` is 1) has these fields: bit 5 selects the source (0 = every instruction cycle, 1 = external pin); bit 4 selects the edge (0 = rising, 1 = falling); bit 3 selects the prescaler owner (1 = watchdog, 0 = timer); bits 2:0 hold the ratio r. With the instruction-cycle source and the prescaler owned by the watchdog, the timer advances once per cycle and wraps from 255 to 0.
- R3: When the timer owns the prescaler, the timer advances once per 2^(r+1) source events (1:2 up to 1:256).
- R4: When the watchdog owns the prescaler, the watchdog counter advances once per 2^r ticks; otherwise it advances on every tick. The cycle after the increment that wraps the counter (2^WB increments), `wdt_to` is high for exactly one cycle.
- R5: With the external source selected, a change on `ext_in` registered at clock edge k is counted at edge k+2, on the chosen edge polarity only.
- R6: When `cmp_sel` is 1, the timer counts edges of `cmp_in` (same polarity bit and same synchronizer latency), and `ext_in` is ignored.
- R7: A timer write loads `tmr_wdata` into the timer. If the timer owns the prescaler, the write also clears it. The two instruction cycles after the write do not advance the timer.
- R8: `wdt_clr` zeroes the watchdog counter and suppresses a time-out in that cycle. It clears the prescaler only when the watchdog owns it. When the timer owns the prescaler, the prescaler keeps its count.
- R9: `pin_dir` is 1 (input) whenever the external pin is the selected source and `cmp_sel` is 0; otherwise it follows `dir_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Load the control word |
| ctl_wdata | input | RW+3 | New control word |
| cmp_sel | input | 1 | Count comparator edges instead of the selected source |
| ext_in | input | 1 | External count pin (asynchronous) |
| cmp_in | input | 1 | Comparator output (asynchronous) |
| dir_req | input | 1 | Requested pin direction (1 = input) |
| tmr_wr | input | 1 | Write the timer |
| tmr_wdata | input | TW | Value to write into the timer |
| wdt_tick | input | 1 | One-cycle pulse from the watchdog oscillator |
| wdt_clr | input | 1 | Watchdog clear instruction |
| tmr_q | output | TW | Timer value |
| wdt_to | output | 1 | Watchdog time-out pulse |
| pin_dir | output | 1 | Effective pin direction (1 = input) |

## Verification
The checker tests properties that hold on every cycle:
- the timer never moves by more than one per cycle except on a write;
- a write lands its value and then holds it for two cycles;
- every time-out follows a watchdog tick with no clear, and lasts a single cycle;
- the pin direction is forced while the external source is active.

Some behaviour depends on counting over many cycles: the division ratios for each owner, the synchronizer latency and edge polarity, the comparator taking over from the pin, and which prescaler a clear or a write resets. Only the bench's scenarios, compared every clock against a behavioural model, can show that behaviour.

// File: rtl/tmr_wdt_prescale.sv
module tmr_wdt_prescale #(
  parameter int TW = 8,
  parameter int RW = 3,
  parameter int WB = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [RW+2:0] ctl_wdata,
  input  logic          cmp_sel,
  input  logic          ext_in,
  input  logic          cmp_in,
  input  logic          dir_req,
  input  logic          tmr_wr,
  input  logic [TW-1:0] tmr_wdata,
  input  logic          wdt_tick,
  input  logic          wdt_clr,
  output logic [TW-1:0] tmr_q,
  output logic          wdt_to,
  output logic          pin_dir
);
  localparam int PW = 1 << RW;
  localparam logic [RW:0] STEP = 1;
  localparam logic [PW:0] UNIT = 1;

  logic [RW+2:0] ctl_q;
  logic [2:0]    ext_s, cmp_s;
  logic [PW-1:0] pre;
  logic [1:0]    hold;
  logic [WB-1:0] wdt_cnt;

  wire src_ext   = ctl_q[RW+2];
  wire edge_fall = ctl_q[RW+1];
  wire to_wdt    = ctl_q[RW];
  wire [RW-1:0] ratio = ctl_q[RW-1:0];

  wire ext_evt = (ext_s[1] ^ edge_fall) & ~(ext_s[2] ^ edge_fall);
  wire cmp_evt = (cmp_s[1] ^ edge_fall) & ~(cmp_s[2] ^ edge_fall);
  wire src_evt = cmp_sel ? cmp_evt : (src_ext ? ext_evt : 1'b1);
  wire t_evt   = src_evt & ~tmr_wr & (hold == 2'd0);

  wire [RW:0] shift  = to_wdt ? {1'b0, ratio} : {1'b0, ratio} + STEP;
  wire [PW:0] mask_w = (UNIT << shift) - UNIT;
  wire        hit    = (pre & mask_w[PW-1:0]) == mask_w[PW-1:0];

  wire pre_evt = to_wdt ? wdt_tick : t_evt;
  wire pre_clr = to_wdt ? wdt_clr : tmr_wr;
  wire tmr_inc = t_evt & (to_wdt | hit);
  wire wdt_inc = wdt_tick & (~to_wdt | hit);

  assign pin_dir = (src_ext & ~cmp_sel) | dir_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '1;
      ext_s   <= '0;
      cmp_s   <= '0;
      pre     <= '0;
      hold    <= '0;
      tmr_q   <= '0;
      wdt_cnt <= '0;
      wdt_to  <= 1'b0;
    end else begin
      ext_s <= {ext_s[1:0], ext_in};
      cmp_s <= {cmp_s[1:0], cmp_in};
      if (ctl_wr) ctl_q <= ctl_wdata;

      if (pre_clr)      pre <= '0;
      else if (pre_evt) pre <= pre + 1'b1;

      if (tmr_wr)       hold <= 2'd2;
      else if (hold != 2'd0) hold <= hold - 2'd1;

      if (tmr_wr)       tmr_q <= tmr_wdata;
      else if (tmr_inc) tmr_q <= tmr_q + 1'b1;

      if (wdt_clr)      wdt_cnt <= '0;
      else if (wdt_inc) wdt_cnt <= wdt_cnt + 1'b1;

      wdt_to <= ~wdt_clr & wdt_inc & (wdt_cnt == '1);
    end
  end
endmodule

module tmr_wdt_prescale_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmr_wr,
  input logic [TW-1:0] tmr_wdata,
  input logic [TW-1:0] tmr_q,
  input logic          wdt_tick,
  input logic          wdt_clr,
  input logic          wdt_to,
  input logic          src_ext,
  input logic          cmp_sel,
  input logic          pin_dir
);
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wr |=> (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) + TW'(1)));

  assert_load_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> tmr_q == $past(tmr_wdata));

  assert_hold_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmr_wr) && !tmr_wr) |=> $stable(tmr_q));

  assert_hold_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmr_wr, 2) && !$past(tmr_wr) && !tmr_wr) |=> $stable(tmr_q));

  assert_to_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_to |=> !wdt_to);

  assert_to_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_to |-> ($past(wdt_tick) && !$past(wdt_clr)));

  assert_dir_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ext && !cmp_sel) |-> pin_dir);
endmodule

bind tmr_wdt_prescale tmr_wdt_prescale_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
  .tmr_q(tmr_q), .wdt_tick(wdt_tick), .wdt_clr(wdt_clr), .wdt_to(wdt_to),
  .src_ext(ctl_q[RW+2]), .cmp_sel(cmp_sel), .pin_dir(pin_dir)
);

// File: tb/tmr_wdt_prescale_test.sv
module tmr_wdt_prescale_test;
  localparam int WB = 4;
  localparam int WMAX = (1 << WB) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, cmp_sel = 0, ext_in = 0, cmp_in = 0, dir_req = 0;
  logic tmr_wr = 0, wdt_tick = 0, wdt_clr = 0;
  logic [5:0] ctl_wdata = 0;
  logic [7:0] tmr_wdata = 0;
  logic [7:0] tmr_q;
  logic wdt_to, pin_dir;

  always #10 clk = ~clk;

  tmr_wdt_prescale #(.TW(8), .RW(3), .WB(WB)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cmp_sel(cmp_sel), .ext_in(ext_in), .cmp_in(cmp_in), .dir_req(dir_req),
    .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .wdt_tick(wdt_tick),
    .wdt_clr(wdt_clr), .tmr_q(tmr_q), .wdt_to(wdt_to), .pin_dir(pin_dir));

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  // behavioural reference model
  bit [5:0] m_opt;
  int m_tmr, m_pre, m_wdt, m_hold;
  bit m_to;
  bit eq[$];
  bit cq[$];

  function automatic bit seen(bit nw, bit od, bit fall);
    return fall ? (!nw && od) : (nw && !od);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_opt = 6'h3F; m_tmr = 0; m_pre = 0; m_wdt = 0; m_hold = 0; m_to = 0;
      eq = '{0, 0, 0}; cq = '{0, 0, 0};
    end else begin
      bit to_w, src, tev, hit, pe, tinc, winc;
      int k, dv;
      to_w = m_opt[3];
      k = to_w ? int'(m_opt[2:0]) : int'(m_opt[2:0]) + 1;
      dv = 1 << k;
      if (cmp_sel) src = seen(cq[1], cq[2], m_opt[4]);
      else if (m_opt[5]) src = seen(eq[1], eq[2], m_opt[4]);
      else src = 1;
      tev = src && !tmr_wr && m_hold == 0;
      hit = (m_pre % dv) == dv - 1;
      pe = to_w ? wdt_tick : tev;
      tinc = to_w ? tev : (tev && hit);
      winc = wdt_tick && (!to_w || hit);
      m_to = !wdt_clr && winc && m_wdt == WMAX;
      if (to_w ? wdt_clr : tmr_wr) m_pre = 0;
      else if (pe) m_pre = (m_pre + 1) % 256;
      if (tmr_wr) m_tmr = int'(tmr_wdata);
      else if (tinc) m_tmr = (m_tmr + 1) % 256;
      if (tmr_wr) m_hold = 2; else if (m_hold > 0) m_hold--;
      if (wdt_clr) m_wdt = 0; else if (winc) m_wdt = (m_wdt + 1) % (WMAX + 1);
      if (ctl_wr) m_opt = ctl_wdata;
      eq.push_front(ext_in); void'(eq.pop_back());
      cq.push_front(cmp_in); void'(cq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(cur_req, int'(tmr_q), m_tmr);
      chk("R4", int'(wdt_to), int'(m_to));
      chk("R9", int'(pin_dir), int'((m_opt[5] && !cmp_sel) || dir_req));
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic set_ctl(input logic [5:0] v);
    ctl_wr = 1; ctl_wdata = v; cyc(); ctl_wr = 0;
  endtask

  task automatic load(input logic [7:0] v);
    tmr_wr = 1; tmr_wdata = v; cyc(); tmr_wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  initial begin
    int n;
    bit seen_to;
    repeat (3) cyc();
    rst_n = 1;
    chk("R1", int'(tmr_q), 0);
    chk("R1", int'(wdt_to), 0);
    chk("R9", int'(pin_dir), 1);

    cur_req = "R2";
    set_ctl(6'b001000);
    chk("R9", int'(pin_dir), 0);
    load(8'd250);
    chk("R7", int'(tmr_q), 250);
    repeat (2) cyc();
    chk("R7", int'(tmr_q), 250);
    repeat (10) cyc();
    chk("R2", int'(tmr_q), 4);

    cur_req = "R3";
    set_ctl(6'b000001);
    load(0); repeat (2) cyc(); repeat (16) cyc();
    chk("R3", int'(tmr_q), 4);
    set_ctl(6'b000000);
    load(0); repeat (2) cyc(); repeat (10) cyc();
    chk("R3", int'(tmr_q), 5);
    set_ctl(6'b000111);
    load(0); repeat (2) cyc(); repeat (255) cyc();
    chk("R3", int'(tmr_q), 0);
    cyc();
    chk("R3", int'(tmr_q), 1);

    cur_req = "R4";
    set_ctl(6'b001010);
    wdt_clr = 1; cyc(); wdt_clr = 0; wdt_tick = 1;
    n = 0;
    do begin cyc(); n++; end while (!wdt_to && n < 300);
    chk("R4", n, 64);
    cyc();
    chk("R4", int'(wdt_to), 0);
    wdt_tick = 0;
    set_ctl(6'b000000);
    wdt_clr = 1; cyc(); wdt_clr = 0; wdt_tick = 1;
    n = 0;
    do begin cyc(); n++; end while (!wdt_to && n < 300);
    chk("R4", n, 16);
    wdt_tick = 0;

    cur_req = "R8";
    set_ctl(6'b001001);
    wdt_clr = 1; cyc(); wdt_clr = 0; wdt_tick = 1;
    repeat (31) cyc();
    wdt_clr = 1; cyc(); wdt_clr = 0;
    seen_to = 0;
    repeat (31) begin cyc(); if (wdt_to) seen_to = 1; end
    chk("R8", int'(seen_to), 0);
    cyc();
    chk("R8", int'(wdt_to), 1);
    wdt_tick = 0;
    set_ctl(6'b000001);
    load(0); repeat (2) cyc(); repeat (2) cyc();
    wdt_clr = 1; cyc(); wdt_clr = 0; cyc();
    chk("R8", int'(tmr_q), 1);

    cur_req = "R5";
    set_ctl(6'b101000);
    load(0); repeat (2) cyc();
    ext_in = 1; cyc(); cyc();
    chk("R5", int'(tmr_q), 0);
    cyc();
    chk("R5", int'(tmr_q), 1);
    ext_in = 0; repeat (3) cyc();
    repeat (4) begin
      ext_in = 1; repeat (2) cyc();
      ext_in = 0; repeat (2) cyc();
    end
    cyc();
    chk("R5", int'(tmr_q), 5);
    chk("R9", int'(pin_dir), 1);
    set_ctl(6'b111000);
    repeat (4) begin
      ext_in = 1; repeat (2) cyc();
      ext_in = 0; repeat (3) cyc();
    end
    chk("R5", int'(tmr_q), 9);

    cur_req = "R6";
    cmp_sel = 1; cyc();
    chk("R9", int'(pin_dir), 0);
    repeat (3) begin
      cmp_in = 1; ext_in = 1; repeat (2) cyc();
      ext_in = 0; repeat (2) cyc();
      ext_in = 1; repeat (2) cyc();
      cmp_in = 0; ext_in = 0; repeat (3) cyc();
    end
    chk("R6", int'(tmr_q), 12);
    cmp_sel = 0; cyc();
    chk("R9", int'(pin_dir), 1);
    dir_req = 1; set_ctl(6'b001000);
    chk("R9", int'(pin_dir), 1);
    repeat (2) cyc();

    report();
    $finish;
  end
endmodule